// File: doc/BRIEF.md
# Nibble Accumulator Processor Core

This block is a small processor core in the manner of the early calculator chips. Its data path is four bits wide and its instructions are one or two bytes long. Every instruction byte takes two clock cycles: one to fetch it, one to execute it. Instructions are read from a program memory with a combinational read port and a 12-bit address. Nibbles are read from and written to a 256-entry data memory through a second port. That data port reads synchronously, with one cycle of latency.

The core holds an accumulator, a carry flag and a zero flag. It has two 8-bit pointer registers, and these pointers are the only way to address data memory. A four-entry internal return stack serves subroutine calls. The arithmetic and logic set is limited to add with carry, subtract with borrow and AND, plus load and store. Branches can test only the carry flag or the zero flag. After reset the core fetches from address 0.

Top module: `nib_cpu`

## Requirements
- R1: While reset is asserted and after it is released, the program counter is 0, so the first fetch is from address 0. No data write is issued in the reset state.
- R2: A one-byte instruction occupies a fetch cycle and then an execute cycle. The program address moves to the next byte at the end of the fetch cycle. A two-byte instruction repeats this pair for its second byte.
- R3: Opcode 0x2p (add) sets A to A + M + C, where M is the nibble at pointer p (bit 0 of the opcode: 0 selects pointer 0, 1 selects pointer 1). C becomes the carry out of bit 3, and Z is set when the 4-bit result is zero.
- R4: Opcode 0x3p (subtract) sets A to A − M − C modulo 16. C becomes 1 when a borrow occurs (A < M + C), and Z follows the result.
- R5: Opcode 0x4p sets A to A AND M and updates Z. C is left unchanged. Only the add and subtract opcodes ever change C.
- R6: Opcode 0x1n loads the immediate n into A and 0x5p loads M into A. Both update Z and leave C unchanged. Opcode 0x6p writes A to the nibble at pointer p and changes no flag.
- R7: Opcodes 0x8n/0x9n write n into the low/high nibble of pointer 0, and 0xAn/0xBn do the same for pointer 1. Opcode 0x7p increments pointer p modulo 256.
- R8: A two-byte branch has 0xC (jump), 0xD (jump if C=1) or 0xE (jump if Z=1) in the high nibble of its first byte. Its target is {low nibble of the first byte, second byte}. A branch that is not taken continues after the second byte.
- R9: Opcode 0xFh followed by a byte is a call: it pushes the address after itself and jumps to the 12-bit target. Opcode 0x01 returns to the most recently pushed address. The stack holds 4 entries, and a call made with 4 entries present discards the oldest one.
- R10: A return made with an empty stack continues at address 0.
- R11: For opcodes 0x2p–0x5p, the data address and read strobe are presented during the fetch cycle of that instruction byte, and the returned nibble is used in the execute cycle. A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 12 | Program memory address (program counter) |
| imem_rdata | input | 8 | Instruction byte at imem_addr, combinational |
| dmem_addr | output | 8 | Data memory address from the selected pointer |
| dmem_re | output | 1 | Data read strobe, data expected next cycle |
| dmem_rdata | input | 4 | Data nibble returned one cycle after dmem_re |
| dmem_we | output | 1 | Data write strobe |
| dmem_wdata | output | 4 | Data nibble to write (accumulator) |

## Verification
The bench uses the default four-bit data width and four-entry stack. At that width, every pairing of accumulator value, memory operand and incoming carry (512 cases) can be run through add, subtract and AND. The result, carry and zero flag are read back through stores and conditional branches. With a four-entry stack, a chain of five nested calls followed by returns reaches both the discard-oldest overflow and the return from an empty stack. A further program covers pointer increments with wrap-around and carry branches both taken and not taken.

// File: rtl/nib_cpu.sv
module nib_cpu #(
  parameter int DW    = 4,
  parameter int DEPTH = 4,
  parameter int AW    = 2 * DW,
  parameter int PC_W  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] imem_addr,
  input  logic [7:0]      imem_rdata,
  output logic [AW-1:0]   dmem_addr,
  output logic            dmem_re,
  input  logic [DW-1:0]   dmem_rdata,
  output logic            dmem_we,
  output logic [DW-1:0]   dmem_wdata
);
  localparam int SP_W = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_F, S_E, S_F2, S_E2} state_t;

  state_t          state;
  logic [PC_W-1:0] pc;
  logic [7:0]      ir, lo;
  logic [DW-1:0]   acc;
  logic            cf, zf;
  logic [AW-1:0]   p0, p1;
  logic [PC_W-1:0] stk [DEPTH];
  logic [SP_W-1:0] depth;

  logic            sel, take;
  logic [DW:0]     sum, diff;
  logic [DW-1:0]   andv;

  assign sel        = (state == S_F) ? imem_rdata[0] : ir[0];
  assign dmem_addr  = sel ? p1 : p0;
  assign dmem_re    = (state == S_F) && (imem_rdata[7:4] >= 4'h2) && (imem_rdata[7:4] <= 4'h5);
  assign dmem_we    = (state == S_E) && (ir[7:4] == 4'h6);
  assign dmem_wdata = acc;
  assign imem_addr  = pc;

  assign sum  = {1'b0, acc} + {1'b0, dmem_rdata} + {{DW{1'b0}}, cf};
  assign diff = {1'b0, acc} - {1'b0, dmem_rdata} - {{DW{1'b0}}, cf};
  assign andv = acc & dmem_rdata;

  always_comb begin
    case (ir[7:4])
      4'hD:    take = cf;
      4'hE:    take = zf;
      default: take = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_F;
      pc    <= '0;
      ir    <= '0;
      lo    <= '0;
      acc   <= '0;
      cf    <= 1'b0;
      zf    <= 1'b0;
      p0    <= '0;
      p1    <= '0;
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      case (state)
        S_F: begin
          ir    <= imem_rdata;
          pc    <= pc + 1'b1;
          state <= S_E;
        end
        S_E: begin
          state <= S_F;
          case (ir[7:4])
            4'h0: if (ir[3:0] == 4'h1) begin
              pc <= (depth == 0) ? '0 : stk[0];
              if (depth != 0) begin
                depth <= depth - 1'b1;
                for (int i = 0; i < DEPTH - 1; i++) stk[i] <= stk[i+1];
                stk[DEPTH-1] <= '0;
              end
            end
            4'h1: begin acc <= ir[DW-1:0]; zf <= (ir[DW-1:0] == '0); end
            4'h2: begin acc <= sum[DW-1:0]; cf <= sum[DW]; zf <= (sum[DW-1:0] == '0); end
            4'h3: begin acc <= diff[DW-1:0]; cf <= diff[DW]; zf <= (diff[DW-1:0] == '0); end
            4'h4: begin acc <= andv; zf <= (andv == '0); end
            4'h5: begin acc <= dmem_rdata; zf <= (dmem_rdata == '0); end
            4'h7: if (ir[0]) p1 <= p1 + 1'b1; else p0 <= p0 + 1'b1;
            4'h8: p0[DW-1:0]  <= ir[DW-1:0];
            4'h9: p0[AW-1:DW] <= ir[DW-1:0];
            4'hA: p1[DW-1:0]  <= ir[DW-1:0];
            4'hB: p1[AW-1:DW] <= ir[DW-1:0];
            4'hC, 4'hD, 4'hE, 4'hF: state <= S_F2;
            default: ;
          endcase
        end
        S_F2: begin
          lo    <= imem_rdata;
          pc    <= pc + 1'b1;
          state <= S_E2;
        end
        default: begin
          state <= S_F;
          if (take) pc <= {ir[3:0], lo};
          if (ir[7:4] == 4'hF) begin
            stk[0] <= pc;
            for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
            if (depth != SP_W'(DEPTH)) depth <= depth + 1'b1;
          end
        end
      endcase
    end
  end

  assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));

  assert_fetch_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_F || state == S_F2) |=> (pc == PC_W'($past(pc) + 1'b1)));

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= SP_W'(DEPTH));

  assert_empty_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_E && ir == 8'h01 && depth == 0) |=> (pc == '0));

  assert_carry_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == S_E && (ir[7:4] == 4'h2 || ir[7:4] == 4'h3)) |=> (cf == $past(cf)));
endmodule

// File: tb/nib_cpu_tb.sv
`timescale 1ns/1ps
module nib_cpu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] imem_addr;
  logic [7:0]  imem_rdata;
  logic [7:0]  dmem_addr;
  logic        dmem_re;
  logic [3:0]  dmem_rdata;
  logic        dmem_we;
  logic [3:0]  dmem_wdata;

  logic [7:0] prog [0:4095];
  logic [3:0] dmem [0:255];
  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #4 clk = ~clk;

  nib_cpu u_dut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dmem_wdata(dmem_wdata)
  );

  assign imem_rdata = prog[imem_addr];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    if (dmem_re) dmem_rdata <= dmem[dmem_addr];
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(input int halt, input bit first);
    int k = 0;
    while (imem_addr != 12'(halt + 2) && k < 400) begin
      if (first) begin
        if (k == 0) begin
          chk("R1 reset pc", imem_addr, 0);
          chk("R1 no write in reset state", dmem_we, 0);
        end
        if (k == 1) chk("R2 exec cycle addr", imem_addr, 1);
        if (k == 2) chk("R2 second fetch addr", imem_addr, 1);
        if (k == 3) chk("R2 second exec addr", imem_addr, 2);
        if (k == 6) begin
          chk("R11 read strobe in fetch", dmem_re, 1);
          chk("R11 read address from pointer 1", dmem_addr, 8'h11);
        end
      end
      @(negedge clk);
      k++;
    end
    if (k >= 400) chk("R2 program reached halt", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_mem;
    for (int i = 0; i < 256; i++) dmem[i] = 4'h0;
  endtask

  task automatic alu_prog(input logic [3:0] opn, input logic [3:0] a, input logic cin);
    logic [7:0] b [25];
    b = '{8'hB1, 8'hA1, {4'h1, 3'b0, cin}, 8'h21, 8'h91, 8'h80, {4'h1, a}, {opn, 4'h0},
          8'h92, 8'h60, 8'hE0, 8'h0F, 8'h10, 8'hC0, 8'h10, 8'h11, 8'h81, 8'h60,
          8'hA2, 8'h10, 8'h21, 8'h82, 8'h60, 8'hC0, 8'h17};
    for (int i = 0; i < 25; i++) prog[i] = b[i];
  endtask

  initial begin
    int exp_r, exp_c, exp_z;
    bit first;
    logic [11:0] seen [10];
    logic [11:0] want [10];
    for (int i = 0; i < 4096; i++) prog[i] = 8'h00;
    clear_mem();

    first = 1'b1;
    for (int op = 0; op < 3; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int m = 0; m < 16; m++) begin
          for (int cin = 0; cin < 2; cin++) begin
            clear_mem();
            dmem[8'h10] = 4'(m);
            dmem[8'h11] = 4'hF;
            alu_prog(4'(op + 2), 4'(a), 1'(cin));
            do_reset();
            run_to_halt(23, first);
            first = 1'b0;
            if (op == 0) begin
              exp_r = (a + m + cin) & 15;
              exp_c = (a + m + cin) >> 4;
            end else if (op == 1) begin
              exp_r = (a - m - cin) & 15;
              exp_c = (a < m + cin) ? 1 : 0;
            end else begin
              exp_r = a & m;
              exp_c = cin;
            end
            exp_z = (exp_r == 0) ? 1 : 0;
            if (op == 0) begin
              chk("R3 add result", dmem[8'h20], exp_r);
              chk("R3 add carry", dmem[8'h22], exp_c);
              chk("R3 R8 add zero via branch", dmem[8'h21], exp_z);
            end else if (op == 1) begin
              chk("R4 sub result", dmem[8'h20], exp_r);
              chk("R4 sub borrow", dmem[8'h22], exp_c);
              chk("R4 R8 sub zero via branch", dmem[8'h21], exp_z);
            end else begin
              chk("R5 and result", dmem[8'h20], exp_r);
              chk("R5 and carry kept", dmem[8'h22], exp_c);
              chk("R5 R8 and zero via branch", dmem[8'h21], exp_z);
            end
          end
        end
      end
    end

    begin
      logic [7:0] b [35];
      b = '{8'h91, 8'h8F, 8'h70, 8'h15, 8'h60, 8'hBF, 8'hAF, 8'h71, 8'h19, 8'h61,
            8'h17, 8'h21, 8'hD0, 8'h11, 8'h14, 8'hC0, 8'h12, 8'h13, 8'h81, 8'h60,
            8'h10, 8'h21, 8'hD0, 8'h1B, 8'h16, 8'hC0, 8'h1C, 8'h17, 8'h82, 8'h60,
            8'h51, 8'h83, 8'h60, 8'hC0, 8'h21};
      for (int i = 0; i < 35; i++) prog[i] = b[i];
    end
    clear_mem();
    do_reset();
    run_to_halt(33, 1'b0);
    chk("R7 pointer increment", dmem[8'h20], 5);
    chk("R7 pointer wrap", dmem[8'h00], 9);
    chk("R8 carry branch taken", dmem[8'h21], 3);
    chk("R8 carry branch not taken", dmem[8'h22], 6);
    chk("R6 load from memory", dmem[8'h23], 9);

    for (int i = 0; i < 4096; i++) prog[i] = 8'h00;
    prog[12'h000] = 8'hF1; prog[12'h001] = 8'h00;
    prog[12'h100] = 8'hF2; prog[12'h101] = 8'h00;
    prog[12'h200] = 8'hF3; prog[12'h201] = 8'h00;
    prog[12'h300] = 8'hF4; prog[12'h301] = 8'h00;
    prog[12'h400] = 8'hF5; prog[12'h401] = 8'h00;
    prog[12'h500] = 8'h01;
    prog[12'h402] = 8'h01; prog[12'h302] = 8'h01;
    prog[12'h202] = 8'h01; prog[12'h102] = 8'h01;
    want = '{12'h100, 12'h200, 12'h300, 12'h400, 12'h500,
             12'h402, 12'h302, 12'h202, 12'h102, 12'h000};
    do_reset();
    begin
      int got = 0;
      int guard = 0;
      logic [11:0] prev;
      prev = imem_addr;
      while (got < 10 && guard < 300) begin
        @(negedge clk);
        guard++;
        if (imem_addr != prev && imem_addr != 12'(prev + 1)) begin
          seen[got] = imem_addr;
          got++;
        end
        prev = imem_addr;
      end
      for (int i = 0; i < 10; i++) begin
        if (i < got) begin
          if (i == 9) chk("R10 empty return goes to 0", seen[i], want[i]);
          else chk("R9 call/return sequence", seen[i], want[i]);
        end else chk("R9 missing control transfer", 0, 1);
      end
    end

    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-run clears pc", imem_addr, 0);
    chk("R1 no write during reset", dmem_we, 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule